// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt request lines from peripheral modules. It picks the request to serve by fixed priority and hands the processor the address of the matching entry in a table of 16-bit handler pointers. It has a fixed number of vector slots at the top of a 64-entry table. Each slot is either non-maskable or maskable, and either owns a single request line or is shared by up to four lines. A request pulse sets a pending flag inside the block. The flag gates presentation together with its line enable and, for maskable slots, a global enable.

Once a winner is chosen, the request output and the address are latched and held until the processor accepts. An accept clears the flag of a single-line slot. Flags of a shared slot are handled through an interrupt-vector read port instead. The port reports an even code for the highest-priority pending sub-line of the selected slot, and a read pulse clears the flag it reported.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `vec_addr_o` is 0 and `iv_data_o` is 0.
- R2: Slot k sits at table index 54+k, and its address is 0xFF80 plus twice the index. Slot 0 is therefore 0xFFEC and slot 9 (index 63) is 0xFFFE.
- R3: When several slots can be presented, the slot with the higher index wins.
- R4: Slots 9 and 8 are non-maskable. They are presented even when `gie_i` is 0, but a 0 on the line enable blocks them.
- R5: Slots 0 to 7 are maskable. They are presented only when both the line enable and `gie_i` are 1.
- R6: A one-cycle pulse on `req_i` sets a pending flag that persists. The presented address stays unchanged while `irq_o` is 1 and no accept arrives, even if a higher slot becomes pending.
- R7: An accept while `irq_o` is 1 drops `irq_o` on the next cycle. For a single-line slot, the accept also clears that slot's flag, so the slot is not presented again.
- R8: Slots 1, 4, 6 and 8 are shared. Their lines are 4k to 4k+3, and sub-line j is line 4k+j. `iv_data_o` for the slot in `iv_sel_i` is 2*(j+1) for the lowest pending enabled sub-line j, and 0 if none is pending. An accept leaves the flags of a shared slot set, so the slot is presented again.
- R9: A pulse on `iv_rd_i` clears only the flag whose code `iv_data_o` shows in that cycle.
- R10: For a single-line slot k, only line 4k is used. Pulses on lines 4k+1 to 4k+3 never raise `irq_o` and never show in `iv_data_o`.
- R11: An accept while `irq_o` is 0 is ignored, and pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 40 | Request pulses; line 4k+j is sub-line j of slot k |
| en_i | input | 40 | Per-line enables |
| gie_i | input | 1 | Global enable for maskable slots |
| ack_i | input | 1 | Processor accept pulse |
| iv_sel_i | input | 4 | Slot addressed by the vector read port |
| iv_rd_i | input | 1 | Read strobe; clears the reported flag |
| irq_o | output | 1 | Interrupt presented to the processor |
| vec_addr_o | output | 16 | Table address of the presented slot, 0 when idle |
| iv_data_o | output | 16 | Sub-source code of the selected slot |

## Verification
A request pulse sampled at one edge sets its flag at that edge. `irq_o` and `vec_addr_o` follow at the next edge, so a presentation is due two cycles after the pulse is driven. After an accept, the next winner appears two edges later. `iv_data_o` is combinational on the flags and `iv_sel_i`, so it is read in the same cycle the selector is driven. The clear takes effect at the edge that samples the read strobe.

The bench queues the expected addresses in order. A monitor compares each new rise of `irq_o` at the falling clock edge, so arrival order is checked but not exact cycle counts. Silence checks for blocked or ignored requests wait four cycles. That is longer than the two-cycle presentation delay.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam logic [15:0] TBL_BASE = 16'hFF80;

  // table address of an entry index
  function automatic logic [15:0] entry_addr(input int unsigned idx);
    return TBL_BASE + 16'(2 * idx);
  endfunction
endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int unsigned LINES = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] used_i,
  input  logic [LINES-1:0] set_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] take;

  assign take = set_i & used_i;

  // a new event in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | take;
  end

  assign pend_o = pend_q;

  p_unused_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~used_i) == '0);

  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take != '0) |=> ((pend_o & $past(take)) == $past(take)));
endmodule

// File: rtl/ivc_slot_scan.sv
module ivc_slot_scan #(
  parameter int unsigned       NUM_VEC  = 10,
  parameter int unsigned       SUBS     = 4,
  parameter logic [NUM_VEC-1:0] NMI_MASK = '0,
  localparam int unsigned      LINES    = NUM_VEC * SUBS,
  localparam int unsigned      CODE_W   = $clog2(2 * SUBS + 1)
) (
  input  logic [LINES-1:0]                pend_i,
  input  logic [LINES-1:0]                en_i,
  input  logic                            gie_i,
  output logic [NUM_VEC-1:0]              active_o,
  output logic [NUM_VEC-1:0][SUBS-1:0]    hit_o,
  output logic [NUM_VEC-1:0][CODE_W-1:0]  code_o
);
  for (genvar k = 0; k < NUM_VEC; k++) begin : g_slot
    logic [SUBS-1:0] live;
    assign live = pend_i[k*SUBS +: SUBS] & en_i[k*SUBS +: SUBS];

    // lowest sub-line number has priority
    always_comb begin
      hit_o[k]  = '0;
      code_o[k] = '0;
      for (int j = SUBS - 1; j >= 0; j--) begin
        if (live[j]) begin
          hit_o[k]    = '0;
          hit_o[k][j] = 1'b1;
          code_o[k]   = CODE_W'(2 * (j + 1));
        end
      end
    end

    if (NMI_MASK[k]) begin : g_nmi
      assign active_o[k] = |live;
    end else begin : g_mask
      assign active_o[k] = (|live) & gie_i;
    end
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int unsigned NUM_VEC = 10,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] active_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  // ascending scan, the last (highest) active slot wins
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_VEC; k++) begin
      if (active_i[k]) idx_o = IDX_W'(k);
    end
  end

  assign valid_o = |active_i;

  p_top_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (active_i[idx_o] && ((active_i >> idx_o) == NUM_VEC'(1))));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned        NUM_VEC     = 10,
  parameter int unsigned        SUBS        = 4,
  parameter int unsigned        TBL_DEPTH   = 64,
  parameter logic [NUM_VEC-1:0] NMI_MASK    = 10'b11_0000_0000,
  parameter logic [NUM_VEC-1:0] SHARED_MASK = 10'b01_0101_0010,
  localparam int unsigned       LINES       = NUM_VEC * SUBS,
  localparam int unsigned       IDX_W       = $clog2(NUM_VEC),
  localparam int unsigned       BASE_IDX    = TBL_DEPTH - NUM_VEC,
  localparam int unsigned       CODE_W      = $clog2(2 * SUBS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] en_i,
  input  logic             gie_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] iv_sel_i,
  input  logic             iv_rd_i,
  output logic             irq_o,
  output logic [15:0]      vec_addr_o,
  output logic [15:0]      iv_data_o
);
  logic [LINES-1:0]               used;
  logic [LINES-1:0]               pend;
  logic [LINES-1:0]               clr;
  logic [NUM_VEC-1:0]             active;
  logic [NUM_VEC-1:0][SUBS-1:0]   hit;
  logic [NUM_VEC-1:0][CODE_W-1:0] code;
  logic                           win_valid;
  logic [IDX_W-1:0]               win_idx;
  logic                           irq_q;
  logic [IDX_W-1:0]               slot_q;
  logic                           sel_ok;

  for (genvar k = 0; k < NUM_VEC; k++) begin : g_used
    for (genvar j = 0; j < SUBS; j++) begin : g_line
      if (j == 0 || SHARED_MASK[k]) begin : g_on
        assign used[k*SUBS+j] = 1'b1;
      end else begin : g_off
        assign used[k*SUBS+j] = 1'b0;
      end
    end
  end

  ivc_pending #(.LINES(LINES)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .used_i (used),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  ivc_slot_scan #(.NUM_VEC(NUM_VEC), .SUBS(SUBS), .NMI_MASK(NMI_MASK)) u_scan (
    .pend_i   (pend),
    .en_i     (en_i),
    .gie_i    (gie_i),
    .active_o (active),
    .hit_o    (hit),
    .code_o   (code)
  );

  ivc_arbiter #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .valid_o  (win_valid),
    .idx_o    (win_idx)
  );

  // latch the winner; hold until accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      slot_q <= '0;
    end else if (!irq_q) begin
      if (win_valid) begin
        irq_q  <= 1'b1;
        slot_q <= win_idx;
      end
    end else if (ack_i) begin
      irq_q <= 1'b0;
    end
  end

  assign sel_ok = (int'(iv_sel_i) < NUM_VEC);

  always_comb begin
    clr = '0;
    if (irq_q && ack_i && !SHARED_MASK[slot_q]) clr[int'(slot_q) * SUBS] = 1'b1;
    if (iv_rd_i && sel_ok) clr[int'(iv_sel_i) * SUBS +: SUBS] = hit[iv_sel_i];
  end

  assign irq_o      = irq_q;
  assign vec_addr_o = irq_q ? entry_addr(BASE_IDX + int'(slot_q)) : 16'h0000;
  assign iv_data_o  = sel_ok ? 16'(code[iv_sel_i]) : 16'h0000;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_addr_o)));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o);

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(gie_i) || NMI_MASK[slot_q]));

  p_idle_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_addr_o == 16'h0000));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] req = '0;
  logic [39:0] en = '1;
  logic        gie = 1'b1;
  logic        ack = 1'b0;
  logic [3:0]  iv_sel = '0;
  logic        iv_rd = 1'b0;
  logic        irq_o;
  logic [15:0] vec_addr_o;
  logic [15:0] iv_data_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit irq_seen = 1'b0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .en_i(en), .gie_i(gie),
    .ack_i(ack), .iv_sel_i(iv_sel), .iv_rd_i(iv_rd),
    .irq_o(irq_o), .vec_addr_o(vec_addr_o), .iv_data_o(iv_data_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: each new presentation is compared with the next queued address
  always @(negedge clk) begin
    if (rst_ni) begin
      if (irq_o && !irq_seen) begin
        if (exp_q.size() == 0) check("R3 unexpected presentation", {16'h0, vec_addr_o}, 32'hFFFF_FFFF);
        else check("R2/R3 presented address", {16'h0, vec_addr_o}, {16'h0, exp_q.pop_front()});
      end
      irq_seen = irq_o;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [39:0] lines);
    @(negedge clk); req = lines;
    @(negedge clk); req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq_o) @(negedge clk);
  endtask

  task automatic iv_read(input string tag, input logic [3:0] sel, input logic [15:0] exp);
    @(negedge clk); iv_sel = sel; iv_rd = 1'b1;
    #1 check(tag, {16'h0, iv_data_o}, {16'h0, exp});
    @(negedge clk); iv_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    check("R1 irq after reset", irq_o, 0);
    check("R1 addr after reset", vec_addr_o, 0);
    check("R1 iv after reset", iv_data_o, 0);
    idle(2);
    rst_ni = 1'b1;
    idle(2);
    check("R1 irq idle", irq_o, 0);

    // R2 slot 0 -> 0xFFEC, R7 accept clears single-line flag
    exp_q.push_back(16'hFFEC);
    pulse_req(40'h1);
    wait_irq();
    check("R2 slot0 address", vec_addr_o, 16'hFFEC);
    do_ack();
    check("R7 irq dropped after accept", irq_o, 0);
    idle(4);
    check("R7 flag cleared", irq_o, 0);

    // R3 priority, R6 hold while a higher slot arrives
    exp_q.push_back(16'hFFF6);
    exp_q.push_back(16'hFFFA);
    exp_q.push_back(16'hFFF2);
    pulse_req((40'h1 << 20) | (40'h1 << 12));
    wait_irq();
    check("R3 slot5 beats slot3", vec_addr_o, 16'hFFF6);
    pulse_req(40'h1 << 28);
    idle(2);
    check("R6 irq held", irq_o, 1);
    check("R6 address held", vec_addr_o, 16'hFFF6);
    do_ack();
    wait_irq();
    check("R3 slot7 next", vec_addr_o, 16'hFFFA);
    do_ack();
    wait_irq();
    check("R3 slot3 last", vec_addr_o, 16'hFFF2);
    do_ack();
    idle(4);

    // R5 maskable blocked, R4 non-maskable passes with gie low
    gie = 1'b0;
    pulse_req(40'h1 << 20);
    idle(4);
    check("R5 masked by gie", irq_o, 0);
    exp_q.push_back(16'hFFFE);
    pulse_req(40'h1 << 36);
    wait_irq();
    check("R4 nmi with gie low", vec_addr_o, 16'hFFFE);
    do_ack();
    idle(4);
    check("R5 still masked", irq_o, 0);
    exp_q.push_back(16'hFFF6);
    @(negedge clk); gie = 1'b1;
    wait_irq();
    check("R5 presented after gie", vec_addr_o, 16'hFFF6);
    do_ack();
    idle(4);

    // R4 line enable blocks non-maskable
    @(negedge clk); en[36] = 1'b0;
    pulse_req(40'h1 << 36);
    idle(4);
    check("R4 nmi blocked by enable", irq_o, 0);
    exp_q.push_back(16'hFFFE);
    @(negedge clk); en[36] = 1'b1;
    wait_irq();
    do_ack();
    idle(4);
    check("R7 nmi flag cleared", irq_o, 0);

    // R8/R9 shared slot 4: lines 16..19
    exp_q.push_back(16'hFFF4);
    exp_q.push_back(16'hFFF4);
    pulse_req((40'h1 << 17) | (40'h1 << 18));
    wait_irq();
    do_ack();
    wait_irq();
    check("R8 shared re-presented", vec_addr_o, 16'hFFF4);
    iv_read("R8 iv sub1", 4'd4, 16'd4);
    iv_read("R9 iv sub2 after clear", 4'd4, 16'd6);
    iv_read("R8 iv empty", 4'd4, 16'd0);
    do_ack();
    idle(4);
    check("R9 shared flags cleared", irq_o, 0);

    // R8 disabled sub-line skipped
    gie = 1'b0;
    @(negedge clk); en[16] = 1'b0;
    pulse_req((40'h1 << 16) | (40'h1 << 19));
    iv_read("R8 iv skips disabled", 4'd4, 16'd8);
    iv_read("R9 only reported cleared", 4'd4, 16'd0);
    @(negedge clk); en[16] = 1'b1;
    iv_read("R9 sub0 kept", 4'd4, 16'd2);
    iv_read("R9 sub0 cleared", 4'd4, 16'd0);
    @(negedge clk); gie = 1'b1;
    idle(4);
    check("R9 nothing left", irq_o, 0);

    // R10 unused lines of single-line slots
    pulse_req((40'h1 << 1) | (40'h1 << 13));
    idle(4);
    check("R10 unused lines silent", irq_o, 0);
    iv_read("R10 slot0 iv", 4'd0, 16'd0);
    iv_read("R10 slot3 iv", 4'd3, 16'd0);

    // R11 stray accept
    gie = 1'b0;
    pulse_req(40'h1);
    idle(2);
    do_ack();
    exp_q.push_back(16'hFFEC);
    @(negedge clk); gie = 1'b1;
    wait_irq();
    check("R11 flag kept after stray accept", vec_addr_o, 16'hFFEC);
    do_ack();
    idle(4);
    check("R11 cleared by real accept", irq_o, 0);

    check("R6 all expected presentations seen", exp_q.size(), 0);
    finish_run();
  end
endmodule